// File: doc/BRIEF.md
# Signal Tap Data Capture Unit

This block observes the stream of results leaving a processing core. Each result comes with the program-step address that produced it. The unit has a set of independent capture channels. Each channel holds a step address chosen by the host. When a valid result carries that address, the channel keeps a copy of the word. Software can use this to look at any intermediate point of an algorithm without changing the algorithm.

The upper channels are not exposed to the host. The last two channels drive a stereo serial transmitter that uses I2S framing, so an external converter or analyzer can listen to any two tapped points. Both words are copied into the transmitter at the start of each frame, so the left and right halves of a frame always come from the same moment.

Top module: `sigtap_capture`

## Requirements
- R1: After reset every channel's captured word is zero and every channel's step address is zero. A valid result at step 0 is therefore captured by all channels until they are reprogrammed.
- R2: A cycle with `cfg_we` high loads `cfg_step` into the step register of channel `cfg_ch`. A channel copies `in_data` at the clock edge where `in_valid` is high and `in_step` equals its step register. The new word is visible on `rd_data` in the next cycle. A step write in the same cycle as a match uses the old step.
- R3: A channel keeps its captured word while `in_valid` is low or `in_step` differs from its step register.
- R4: Channels are independent. Channels programmed with the same step all capture the same word, and a step write to one channel does not change any other channel.
- R5: `rd_data` shows, without a cycle of delay, the word of channel `rd_sel` for `rd_sel` 0 to 5. It reads zero for `rd_sel` 6 and 7.
- R6: `ser_bclk` toggles every BCLK_DIV clock cycles and idles low after reset. A frame lasts 64 bit periods. `ser_lrclk` is low for the first 32 bit periods (left) and high for the last 32 (right). It changes only on falling edges of `ser_bclk`, and after reset it is high.
- R7: In each 32-bit slot, bit periods 1 to 24 carry bits 27 down to 4 of the word, MSB first. Bit period 0 is the period right after the `ser_lrclk` transition. Bit periods 0 and 25 to 31 are zero. `ser_data` changes only on falling edges of `ser_bclk`.
- R8: The left slot carries channel 6 and the right slot carries channel 7. Both are copied at the falling edge where `ser_lrclk` goes low. Captures that happen during a frame appear together in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Step-address write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_step | input | 11 | Step address to store |
| in_valid | input | 1 | Result strobe from the core |
| in_step | input | 11 | Program step that produced `in_data` |
| in_data | input | 28 | Result word, two's complement |
| rd_sel | input | 3 | Channel to show on `rd_data` |
| rd_data | output | 28 | Captured word of the selected host channel |
| ser_bclk | output | 1 | Serial bit clock |
| ser_lrclk | output | 1 | Word select: low for left, high for right |
| ser_data | output | 1 | Serial audio data |

## Verification
The assertions assume that `in_data`, `in_step`, `in_valid`, `cfg_*` and `rd_sel` are known and stable at each rising clock edge once reset is released. They also assume that reset is held across at least one edge before those inputs matter. The bench drives every input on the falling clock edge and keeps all strobes low during reset. It programs the step registers only while `in_valid` is low, so each sweep uses a known set of step addresses. The serial stream is decoded on rising `ser_bclk` edges, where the data and word-select lines have been stable for half a bit period.

// File: rtl/sigtap_pkg.sv
`timescale 1ns/1ps
package sigtap_pkg;
  localparam int unsigned WORD_W_DEF = 28;
  localparam int unsigned STEP_W_DEF = 11;
  localparam int unsigned CHAN_DEF   = 8;
  localparam int unsigned TX_W_DEF   = 24;
  localparam int unsigned SLOT_DEF   = 32;
  localparam int unsigned DIV_DEF    = 2;

  typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;
endpackage

// File: rtl/sigtap_channel.sv
`timescale 1ns/1ps
module sigtap_channel #(
  parameter int unsigned DATA_W = sigtap_pkg::WORD_W_DEF,
  parameter int unsigned STEP_W = sigtap_pkg::STEP_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [STEP_W-1:0] cfg_step,
  input  logic              in_valid,
  input  logic [STEP_W-1:0] in_step,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] cap_q
);
  logic [STEP_W-1:0] step_q;
  logic              hit;

  // Compare against the register value held before any same-cycle write.
  assign hit = in_valid && (in_step == step_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      cap_q  <= '0;
    end else begin
      if (cfg_we) step_q <= cfg_step;
      if (hit)    cap_q  <= in_data;
    end
  end

  // R2: a match copies the presented word
  a_r2_latch_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cap_q == $past(in_data)));

  // R3: no match means the word is kept
  a_r3_hold_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap_q));

  // R4: the step register changes only when this channel is written
  a_r4_step_private: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(step_q));
endmodule

// File: rtl/sigtap_i2s_tx.sv
`timescale 1ns/1ps
module sigtap_i2s_tx #(
  parameter int unsigned DATA_W   = sigtap_pkg::WORD_W_DEF,
  parameter int unsigned OUT_W    = sigtap_pkg::TX_W_DEF,
  parameter int unsigned SLOT_W   = sigtap_pkg::SLOT_DEF,
  parameter int unsigned BCLK_DIV = sigtap_pkg::DIV_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  output logic              bclk,
  output logic              lrclk,
  output logic              sdata
);
  localparam int unsigned POS_W = $clog2(2 * SLOT_W);
  localparam int unsigned DIV_W = $clog2(BCLK_DIV + 1);
  localparam logic [POS_W-1:0] SLOT_POS = POS_W'(SLOT_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(2 * SLOT_W - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BCLK_DIV - 1);

  logic [DIV_W-1:0]  div_q;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  pos_nx;
  logic [POS_W-1:0]  slot_k;
  logic [DATA_W-1:0] sh_l, sh_r;
  logic              bclk_q, lr_q, sd_q;
  logic              half_tick, fall_tick, frame_start;
  sigtap_pkg::side_e side_nx;

  // Bit period k (1..OUT_W) of a slot carries word bit DATA_W-k. All others are zero.
  function automatic logic slot_bit(input logic [DATA_W-1:0] w, input logic [POS_W-1:0] k);
    logic b;
    b = 1'b0;
    for (int i = 1; i <= int'(OUT_W); i++)
      if (k == POS_W'(i)) b = w[DATA_W-i];
    return b;
  endfunction

  assign half_tick   = (div_q == DIV_LAST);
  assign fall_tick   = half_tick && bclk_q;
  assign pos_nx      = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  assign frame_start = fall_tick && (pos_nx == '0);
  assign side_nx     = (pos_nx >= SLOT_POS) ? sigtap_pkg::SIDE_RIGHT : sigtap_pkg::SIDE_LEFT;
  assign slot_k      = (pos_q >= SLOT_POS) ? pos_q - SLOT_POS : pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
      pos_q  <= LAST_POS;
      lr_q   <= 1'b1;
      sd_q   <= 1'b0;
      sh_l   <= '0;
      sh_r   <= '0;
    end else begin
      div_q <= half_tick ? '0 : div_q + 1'b1;
      if (half_tick) bclk_q <= ~bclk_q;
      if (fall_tick) begin
        pos_q <= pos_nx;
        lr_q  <= side_nx;
        sd_q  <= (side_nx == sigtap_pkg::SIDE_RIGHT) ? slot_bit(sh_r, pos_nx - SLOT_POS)
                                                     : slot_bit(sh_l, pos_nx);
      end
      if (frame_start) begin
        sh_l <= left_in;
        sh_r <= right_in;
      end
    end
  end

  assign bclk  = bclk_q;
  assign lrclk = lr_q;
  assign sdata = sd_q;

  // R6: word select moves only with a falling bit clock
  a_r6_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lr_q) |-> $fell(bclk_q));

  // R7: data line moves only with a falling bit clock
  a_r7_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_q) |-> $fell(bclk_q));

  // R7: a one can only appear inside the payload bit periods
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sd_q |-> (slot_k >= POS_W'(1) && slot_k <= POS_W'(OUT_W)));

  // R8: the frame copies are refreshed only at a frame start
  a_r8_frame_copy: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(sh_l) && $stable(sh_r)));

  // R8: a frame start always drives word select low
  a_r8_start_left: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !lr_q);
endmodule

// File: rtl/sigtap_capture.sv
`timescale 1ns/1ps
module sigtap_capture #(
  parameter int unsigned DATA_W   = sigtap_pkg::WORD_W_DEF,
  parameter int unsigned STEP_W   = sigtap_pkg::STEP_W_DEF,
  parameter int unsigned NUM_CH   = sigtap_pkg::CHAN_DEF,
  parameter int unsigned OUT_W    = sigtap_pkg::TX_W_DEF,
  parameter int unsigned SLOT_W   = sigtap_pkg::SLOT_DEF,
  parameter int unsigned BCLK_DIV = sigtap_pkg::DIV_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CH)-1:0] cfg_ch,
  input  logic [STEP_W-1:0]         cfg_step,
  input  logic                      in_valid,
  input  logic [STEP_W-1:0]         in_step,
  input  logic [DATA_W-1:0]         in_data,
  input  logic [$clog2(NUM_CH)-1:0] rd_sel,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      ser_bclk,
  output logic                      ser_lrclk,
  output logic                      ser_data
);
  localparam int unsigned SEL_W    = $clog2(NUM_CH);
  localparam int unsigned NUM_HOST = NUM_CH - 2;
  localparam int unsigned LEFT_CH  = NUM_CH - 2;
  localparam int unsigned RIGHT_CH = NUM_CH - 1;
  localparam logic [SEL_W-1:0] HOST_LIM = SEL_W'(NUM_HOST);

  logic [NUM_CH-1:0][DATA_W-1:0] cap_all;
  logic [NUM_CH-1:0]             wr_sel;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign wr_sel[c] = cfg_we && (cfg_ch == SEL_W'(c));
    sigtap_channel #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (wr_sel[c]),
      .cfg_step (cfg_step),
      .in_valid (in_valid),
      .in_step  (in_step),
      .in_data  (in_data),
      .cap_q    (cap_all[c])
    );
  end

  // R5: only the host channels are visible
  assign rd_data = (rd_sel < HOST_LIM) ? cap_all[rd_sel] : '0;

  sigtap_i2s_tx #(
    .DATA_W(DATA_W), .OUT_W(OUT_W), .SLOT_W(SLOT_W), .BCLK_DIV(BCLK_DIV)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .left_in  (cap_all[LEFT_CH]),
    .right_in (cap_all[RIGHT_CH]),
    .bclk     (ser_bclk),
    .lrclk    (ser_lrclk),
    .sdata    (ser_data)
  );

  // R4: a write strobe reaches at most one channel
  a_r4_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R5: the stereo channels never appear on the read port
  a_r5_stereo_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel >= HOST_LIM) |-> (rd_data == '0));
endmodule

// File: tb/sim_sigtap_capture.sv
`timescale 1ns/1ps
module sim_sigtap_capture;
  localparam int DW = 28;
  localparam int SW = 11;
  localparam int NCH = 8;
  localparam int NH = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_ch = '0;
  logic [SW-1:0] cfg_step = '0;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_step = '0;
  logic [DW-1:0] in_data = '0;
  logic [2:0]    rd_sel = '0;
  logic [DW-1:0] rd_data;
  logic          bclk, lrclk, sdata;
  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  sigtap_capture u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_step(cfg_step),
    .in_valid(in_valid), .in_step(in_step), .in_data(in_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .ser_bclk(bclk), .ser_lrclk(lrclk), .ser_data(sdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int s, input int salt);
    return DW'((s * 40503 + 977 + salt * 7919) ^ (s << 13));
  endfunction

  function automatic int tap(input int c);
    return c * 251 + 17;
  endfunction

  task automatic prog(input int ch, input int st);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_step = SW'(st);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic feed(input int st, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_step = SW'(st); in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd(input int sel, output logic [DW-1:0] v);
    @(negedge clk);
    rd_sel = 3'(sel);
    #1 v = rd_data;
  endtask

  // Decode one frame. Optionally capture new stereo words while it is being sent.
  task automatic grab(output logic [23:0] lw, output logic [23:0] rw, output logic bad_lr,
                      output logic bad_pad, input logic mid, input logic [DW-1:0] nl,
                      input logic [DW-1:0] nr);
    logic prev;
    prev = 1'b0;
    forever begin
      @(posedge bclk); @(negedge clk);
      if (!lrclk && prev) break;
      prev = lrclk;
    end
    lw = '0; rw = '0; bad_lr = 1'b0; bad_pad = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i > 0) begin @(posedge bclk); @(negedge clk); end
      if (lrclk !== (i >= 32)) bad_lr = 1'b1;
      if (i >= 1 && i <= 24) lw = {lw[22:0], sdata};
      else if (i >= 33 && i <= 56) rw = {rw[22:0], sdata};
      else if (sdata !== 1'b0) bad_pad = 1'b1;
      if (mid && i == 8)  feed(tap(6), nl);
      if (mid && i == 40) feed(tap(7), nr);
    end
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [23:0] lw, rw;
    logic blr, bpad;
    realtime t0, t1;

    repeat (3) @(negedge clk);
    chk("R6 bclk idle in reset", 32'(bclk), 32'd0);
    chk("R6 lrclk high in reset", 32'(lrclk), 32'd1);
    chk("R7 data low in reset", 32'(sdata), 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      rd(c, v);
      chk($sformatf("R1 reset word ch%0d", c), 32'(v), 32'd0);
    end

    // R1: all step registers start at zero
    feed(0, 28'h1234567);
    for (int c = 0; c < NH; c++) begin
      rd(c, v);
      chk($sformatf("R1 step zero capture ch%0d", c), 32'(v), 32'h1234567);
    end

    // R2: full sweep of every step address
    for (int c = 0; c < NCH; c++) prog(c, tap(c));
    for (int s = 0; s < (1 << SW); s++) begin
      @(negedge clk);
      in_valid = 1'b1; in_step = SW'(s); in_data = pat(s, 0);
    end
    @(negedge clk); in_valid = 1'b0;
    for (int c = 0; c < NH; c++) begin
      rd(c, v);
      chk($sformatf("R2 sweep ch%0d", c), 32'(v), 32'(pat(tap(c), 0)));
    end
    for (int c = NH; c < NCH; c++) begin
      rd(c, v);
      chk($sformatf("R5 stereo channel hidden sel%0d", c), 32'(v), 32'd0);
    end

    // R3: sweep with the strobe low, then with valid results at unused steps
    for (int s = 0; s < (1 << SW); s++) begin
      @(negedge clk);
      in_valid = 1'b0; in_step = SW'(s); in_data = pat(s, 1);
    end
    for (int s = 1; s < 17; s++) begin
      @(negedge clk);
      in_valid = 1'b1; in_step = SW'(s); in_data = pat(s, 2);
    end
    @(negedge clk); in_valid = 1'b0;
    for (int c = 0; c < NH; c++) begin
      rd(c, v);
      chk($sformatf("R3 hold ch%0d", c), 32'(v), 32'(pat(tap(c), 0)));
    end

    // R4: two channels share a step, others unaffected
    prog(0, 5); prog(1, 5);
    feed(5, 28'hA5A5A5A);
    rd(0, v); chk("R4 shared step ch0", 32'(v), 32'hA5A5A5A);
    rd(1, v); chk("R4 shared step ch1", 32'(v), 32'hA5A5A5A);
    rd(2, v); chk("R4 neighbour ch2", 32'(v), 32'(pat(tap(2), 0)));
    feed(tap(2), 28'h0000111);
    rd(2, v); chk("R4 neighbour step kept ch2", 32'(v), 32'h0000111);

    // R6: bit clock period
    @(posedge bclk); t0 = $realtime;
    @(posedge bclk); t1 = $realtime;
    chk("R6 bclk period ns", 32'(int'(t1 - t0)), 32'd40);

    // R7 R8: stereo words from the sweep
    grab(lw, rw, blr, bpad, 1'b0, '0, '0);
    chk("R8 left word", 32'(lw), 32'(pat(tap(6), 0) >> 4));
    chk("R8 right word", 32'(rw), 32'(pat(tap(7), 0) >> 4));
    chk("R6 lrclk pattern", 32'(blr), 32'd0);
    chk("R7 padding zero", 32'(bpad), 32'd0);

    // R8: captures during a frame appear together in the following frame
    grab(lw, rw, blr, bpad, 1'b1, 28'hF123456, 28'h0ABCDEF);
    chk("R8 mid-frame left unchanged", 32'(lw), 32'(pat(tap(6), 0) >> 4));
    chk("R8 mid-frame right unchanged", 32'(rw), 32'(pat(tap(7), 0) >> 4));
    grab(lw, rw, blr, bpad, 1'b0, '0, '0);
    chk("R7 negative left word", 32'(lw), 32'hF12345);
    chk("R7 right word", 32'(rw), 32'h0ABCDE);
    chk("R6 lrclk pattern second", 32'(blr), 32'd0);
    chk("R7 padding zero second", 32'(bpad), 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule